// File: doc/BRIEF.md
# Dual-Issue Packet Pairing Scheduler

This block sits at the global decode point of a two-wide in-order pipeline. Each cycle it is offered a decode packet of two instructions in fixed order, slot-a first and slot-b second. Each instruction arrives already tagged with its execution group, a flag that says it must issue alone, a flag that marks a special-register or FP-status write, and its register source and destination indices. The block judges the packet against a scoreboard of registers whose results are still in flight. It then launches both instructions, launches slot-a alone and keeps slot-b, or holds the whole packet.

Two states drive the control. In state ST_PAIR the block judges the packet that upstream presents. ST_PAIR has three outcomes. If slot-a waits on the scoreboard, the packet is held. If the two instructions may go together, both launch and the packet is taken. Otherwise the packet splits: slot-a launches, slot-b is copied into a pending register, and the transition ST_PAIR to ST_SOLO fires. In ST_SOLO the pending instruction is judged alone, in the issue position of slot-a. The upstream packet is not taken in this state. The pending instruction either holds, or launches and takes the transition ST_SOLO to ST_PAIR.

A separate counter keeps issue serial for a short window after a special-register write. A pairing-rules unit applies the group table and its two same-group exceptions.

Top module: `dual_issue_pairer`

## Requirements
- R1: After reset the block is in ST_PAIR. With pkt_valid low, all five outputs launch_a, launch_b, split, hold and pkt_taken are 0.
- R2: In ST_PAIR, if a nonzero source of slot-a is marked busy in sb_busy, the block asserts hold. In that case launch_a, launch_b and pkt_taken are all 0.
- R3: If slot-a may launch, slot-b is valid, and a_single or b_single is 1, then slot-a launches alone, split is 1 and launch_b is 0.
- R4: Group codes are 0 load/store, 1 ALU, 2 FP and 3 branch-type. Two instructions from different groups may pair. Two load/store instructions never pair, and neither do two branch-type instructions. Two FP instructions pair only when fpq_full is 0.
- R5: Two ALU instructions pair only as a fast constant. A fast constant needs a_konst_hi and b_konst_lo both 1, a nonzero a_dst, and b_src1 equal to a_dst. In that case b_src1 is checked neither against slot-a nor against the scoreboard.
- R6: If slot-b reads, through b_src1 or b_src2, the nonzero a_dst, the packet splits. The fast-constant case of R5 is the exception.
- R7: If slot-a is free of the scoreboard but a nonzero source of slot-b is busy, slot-a launches and the packet splits.
- R8: After a split the block is in ST_SOLO. In that state pkt_taken is 0. The kept slot-b instruction launches on launch_a once its sources are not busy, and hold is 1 until then.
- R9: An instruction with its sreg flag set splits its packet in the same way as a single-launch instruction. After it launches, the next three launched instructions each issue alone.
- R10: Register index 0 is never a dependency, whatever sb_busy bit 0 holds.
- R11: A packet with b_valid 0 is taken when slot-a launches. split is then 0, and launch_b is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A decode packet is presented; it is held until taken |
| a_grp | input | 2 | Slot-a group code |
| a_single | input | 1 | Slot-a must issue alone |
| a_sreg | input | 1 | Slot-a writes a special or FP-status register |
| a_konst_hi | input | 1 | Slot-a sets the high part of a constant |
| a_src1 | input | REG_W | Slot-a first source register |
| a_src2 | input | REG_W | Slot-a second source register |
| a_dst | input | REG_W | Slot-a destination register (0 means none) |
| b_valid | input | 1 | Slot-b holds an instruction |
| b_grp | input | 2 | Slot-b group code |
| b_single | input | 1 | Slot-b must issue alone |
| b_sreg | input | 1 | Slot-b writes a special or FP-status register |
| b_konst_lo | input | 1 | Slot-b merges a low immediate into a constant |
| b_src1 | input | REG_W | Slot-b first source register |
| b_src2 | input | REG_W | Slot-b second source register |
| sb_busy | input | 2**REG_W | Registers with results still in flight |
| fpq_full | input | 1 | FP pre-queue has no free entry |
| launch_a | output | 1 | Instruction in issue position a launches |
| launch_b | output | 1 | Slot-b launches together with slot-a |
| split | output | 1 | Slot-a launches alone and slot-b is kept |
| hold | output | 1 | Nothing launches this cycle |
| pkt_taken | output | 1 | The presented packet is consumed |

## Verification
Two functions can decide the same cycle. The first is the serial window that follows a special-register write. The second is an ordinary reason to split, such as a single-launch flag, an illegal group pair, an intra-packet dependency, or slot-b waiting on the scoreboard. The bench provokes the overlap by sweeping every group pair against every flag variant, with short register indices so that collisions are frequent and scoreboard bits that are sparse and change each cycle. Its own model of the states and the window names the rule that decides each cycle, and it judges all five outputs against that rule.

// File: rtl/dip_pkg.sv
package dip_pkg;

    typedef enum logic [1:0] {
        GRP_LS  = 2'd0,
        GRP_ALU = 2'd1,
        GRP_FP  = 2'd2,
        GRP_BR  = 2'd3
    } grp_e;

    typedef enum logic {
        ST_PAIR = 1'b0,
        ST_SOLO = 1'b1
    } sched_state_e;

endpackage

// File: rtl/dip_hazard.sv
module dip_hazard #(
    parameter int REG_W = 5
) (
    input  logic [(1<<REG_W)-1:0] sb_busy,
    input  logic [REG_W-1:0]      src1,
    input  logic [REG_W-1:0]      src2,
    input  logic                  waive1,
    output logic                  blocked
);
    localparam int NSRC = 2;

    logic [REG_W-1:0] srcs [NSRC];
    logic [NSRC-1:0]  hit;

    assign srcs[0] = src1;
    assign srcs[1] = src2;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // Index 0 is the constant-zero register and never waits.
        if (i == 0) begin : g_waivable
            assign hit[i] = (srcs[i] != '0) && sb_busy[srcs[i]] && !waive1;
        end else begin : g_plain
            assign hit[i] = (srcs[i] != '0) && sb_busy[srcs[i]];
        end
    end

    assign blocked = |hit;

endmodule

// File: rtl/dip_pair_rules.sv
module dip_pair_rules
    import dip_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [1:0]       a_grp,
    input  logic [1:0]       b_grp,
    input  logic             a_konst_hi,
    input  logic             b_konst_lo,
    input  logic [REG_W-1:0] a_dst,
    input  logic [REG_W-1:0] b_src1,
    input  logic [REG_W-1:0] b_src2,
    input  logic             fpq_full,
    output logic             fast_k,
    output logic             table_ok,
    output logic             intra_dep
);
    logic same_grp;
    logic a_writes;

    assign a_writes = (a_dst != '0);
    assign same_grp = (a_grp == b_grp);

    // Constant built by concatenating the two immediates.
    assign fast_k = a_konst_hi && b_konst_lo
                 && (a_grp == GRP_ALU) && (b_grp == GRP_ALU)
                 && a_writes && (b_src1 == a_dst);

    always_comb begin
        table_ok = 1'b0;
        if (!same_grp) begin
            table_ok = 1'b1;
        end else begin
            unique case (a_grp)
                GRP_FP:  table_ok = !fpq_full;
                GRP_ALU: table_ok = fast_k;
                GRP_LS:  table_ok = 1'b0;
                GRP_BR:  table_ok = 1'b0;
                default: table_ok = 1'b0;
            endcase
        end
    end

    assign intra_dep = a_writes
                    && (((b_src1 == a_dst) && !fast_k) || (b_src2 == a_dst));

endmodule

// File: rtl/dip_serial_window.sv
module dip_serial_window #(
    parameter int SERIAL_WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic active
);
    localparam int CNT_W = $clog2(SERIAL_WIN + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SERIAL_WIN);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
    import dip_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int SERIAL_WIN = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pkt_valid,
    input  logic [1:0]            a_grp,
    input  logic                  a_single,
    input  logic                  a_sreg,
    input  logic                  a_konst_hi,
    input  logic [REG_W-1:0]      a_src1,
    input  logic [REG_W-1:0]      a_src2,
    input  logic [REG_W-1:0]      a_dst,
    input  logic                  b_valid,
    input  logic [1:0]            b_grp,
    input  logic                  b_single,
    input  logic                  b_sreg,
    input  logic                  b_konst_lo,
    input  logic [REG_W-1:0]      b_src1,
    input  logic [REG_W-1:0]      b_src2,
    input  logic [(1<<REG_W)-1:0] sb_busy,
    input  logic                  fpq_full,
    output logic                  launch_a,
    output logic                  launch_b,
    output logic                  split,
    output logic                  hold,
    output logic                  pkt_taken
);
    sched_state_e state_q, state_d;

    logic             p_sreg_q;
    logic [REG_W-1:0] p_src1_q, p_src2_q;
    logic             capture;

    logic a_blk, b_blk, p_blk;
    logic fast_k, table_ok, intra_dep;
    logic serial_active;
    logic lone_only;
    logic pair_ok;
    logic win_load;

    dip_hazard #(.REG_W(REG_W)) u_haz_a (
        .sb_busy (sb_busy),
        .src1    (a_src1),
        .src2    (a_src2),
        .waive1  (1'b0),
        .blocked (a_blk)
    );

    dip_hazard #(.REG_W(REG_W)) u_haz_b (
        .sb_busy (sb_busy),
        .src1    (b_src1),
        .src2    (b_src2),
        .waive1  (fast_k),
        .blocked (b_blk)
    );

    dip_hazard #(.REG_W(REG_W)) u_haz_p (
        .sb_busy (sb_busy),
        .src1    (p_src1_q),
        .src2    (p_src2_q),
        .waive1  (1'b0),
        .blocked (p_blk)
    );

    dip_pair_rules #(.REG_W(REG_W)) u_rules (
        .a_grp      (a_grp),
        .b_grp      (b_grp),
        .a_konst_hi (a_konst_hi),
        .b_konst_lo (b_konst_lo),
        .a_dst      (a_dst),
        .b_src1     (b_src1),
        .b_src2     (b_src2),
        .fpq_full   (fpq_full),
        .fast_k     (fast_k),
        .table_ok   (table_ok),
        .intra_dep  (intra_dep)
    );

    dip_serial_window #(.SERIAL_WIN(SERIAL_WIN)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (win_load),
        .dec    (launch_a),
        .active (serial_active)
    );

    assign lone_only = a_single || b_single || a_sreg || b_sreg || serial_active;
    assign pair_ok   = !lone_only && table_ok && !intra_dep && !b_blk;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PAIR;
        end else begin
            state_q <= state_d;
        end
    end

    // Pending slot-b, kept across a split.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_sreg_q <= 1'b0;
            p_src1_q <= '0;
            p_src2_q <= '0;
        end else if (capture) begin
            p_sreg_q <= b_sreg;
            p_src1_q <= b_src1;
            p_src2_q <= b_src2;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_PAIR: begin
                if (pkt_valid && !a_blk && b_valid && !pair_ok) begin
                    state_d = ST_SOLO;
                    capture = 1'b1;
                end
            end
            ST_SOLO: begin
                if (!p_blk) begin
                    state_d = ST_PAIR;
                end
            end
            default: state_d = ST_PAIR;
        endcase
    end

    // Outputs.
    always_comb begin
        launch_a  = 1'b0;
        launch_b  = 1'b0;
        split     = 1'b0;
        hold      = 1'b0;
        pkt_taken = 1'b0;
        win_load  = 1'b0;
        unique case (state_q)
            ST_PAIR: begin
                if (pkt_valid) begin
                    if (a_blk) begin
                        hold = 1'b1;
                    end else begin
                        launch_a  = 1'b1;
                        pkt_taken = 1'b1;
                        win_load  = a_sreg;
                        if (b_valid) begin
                            launch_b = pair_ok;
                            split    = !pair_ok;
                        end
                    end
                end
            end
            ST_SOLO: begin
                if (p_blk) begin
                    hold = 1'b1;
                end else begin
                    launch_a = 1'b1;
                    win_load = p_sreg_q;
                end
            end
            default: hold = 1'b0;
        endcase
    end

endmodule

// File: rtl/dual_issue_pairer_chk.sv
module dual_issue_pairer_chk #(
    parameter int REG_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            a_grp,
    input logic                  a_single,
    input logic                  a_sreg,
    input logic [REG_W-1:0]      a_src1,
    input logic                  b_valid,
    input logic [1:0]            b_grp,
    input logic                  b_single,
    input logic [(1<<REG_W)-1:0] sb_busy,
    input logic                  launch_a,
    input logic                  launch_b,
    input logic                  split,
    input logic                  hold,
    input logic                  pkt_taken
);
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!launch_a && !launch_b && !pkt_taken)); // R2

    AST_A_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_taken |-> !((a_src1 != '0) && sb_busy[a_src1])); // R2

    AST_SINGLE_SPLITS: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_taken && b_valid && (a_single || b_single)) |-> split); // R3

    AST_B_WITH_A: assert property (@(posedge clk) disable iff (!rst_n)
        launch_b |-> (launch_a && pkt_taken)); // R4

    AST_NO_LS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        launch_b |-> !((a_grp == 2'd0) && (b_grp == 2'd0))); // R4

    AST_NO_BR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        launch_b |-> !((a_grp == 2'd3) && (b_grp == 2'd3))); // R4

    AST_SPLIT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        split |-> (launch_a && !launch_b)); // R7

    AST_SPLIT_THEN_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        split |=> !pkt_taken); // R8

    AST_SREG_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_taken && a_sreg) |=> !launch_b); // R9

endmodule

bind dual_issue_pairer dual_issue_pairer_chk #(.REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_grp     (a_grp),
    .a_single  (a_single),
    .a_sreg    (a_sreg),
    .a_src1    (a_src1),
    .b_valid   (b_valid),
    .b_grp     (b_grp),
    .b_single  (b_single),
    .sb_busy   (sb_busy),
    .launch_a  (launch_a),
    .launch_b  (launch_b),
    .split     (split),
    .hold      (hold),
    .pkt_taken (pkt_taken)
);

// File: tb/dual_issue_pairer_bench.sv
module dual_issue_pairer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W = 5;
    localparam int NREG  = 1 << REG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0;
    logic [1:0] a_grp = '0, b_grp = '0;
    logic a_single = 0, a_sreg = 0, a_konst_hi = 0;
    logic b_valid = 0, b_single = 0, b_sreg = 0, b_konst_lo = 0;
    logic [REG_W-1:0] a_src1 = '0, a_src2 = '0, a_dst = '0, b_src1 = '0, b_src2 = '0;
    logic [NREG-1:0] sb_busy = '0;
    logic fpq_full = 1'b0;
    logic launch_a, launch_b, split, hold, pkt_taken;

    int checks = 0;
    int errors = 0;
    int unsigned seed = 32'h1234_5678;

    // Reference state.
    bit m_solo = 0;
    bit m_p_sreg = 0;
    logic [REG_W-1:0] m_p_src1 = '0, m_p_src2 = '0;
    int m_cnt = 0;
    bit e_la, e_lb, e_sp, e_hd, e_tk;
    string reason;
    bit rnd_sb = 0;
    int holds = 0;

    dual_issue_pairer u_dual_issue_pairer (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .a_grp(a_grp), .a_single(a_single), .a_sreg(a_sreg), .a_konst_hi(a_konst_hi),
        .a_src1(a_src1), .a_src2(a_src2), .a_dst(a_dst),
        .b_valid(b_valid), .b_grp(b_grp), .b_single(b_single), .b_sreg(b_sreg),
        .b_konst_lo(b_konst_lo), .b_src1(b_src1), .b_src2(b_src2),
        .sb_busy(sb_busy), .fpq_full(fpq_full),
        .launch_a(launch_a), .launch_b(launch_b), .split(split), .hold(hold),
        .pkt_taken(pkt_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int unsigned lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic bit busy(logic [REG_W-1:0] r);
        return (r != 0) && sb_busy[r];
    endfunction

    task automatic compute_expected();
        bit fk, intra, bblk, tbl, lone;
        {e_la, e_lb, e_sp, e_hd, e_tk} = '0;
        if (m_solo) begin
            reason = "R8";
            if (busy(m_p_src1) || busy(m_p_src2)) e_hd = 1;
            else e_la = 1;
        end else if (!pkt_valid) begin
            reason = "R1";
        end else if (busy(a_src1) || busy(a_src2)) begin
            reason = (a_src1 == 0 && a_src2 == 0) ? "R10" : "R2";
            e_hd = 1;
        end else begin
            e_la = 1; e_tk = 1;
            if (!b_valid) begin
                reason = "R11";
            end else begin
                fk = a_konst_hi && b_konst_lo && a_grp == 1 && b_grp == 1
                     && a_dst != 0 && b_src1 == a_dst;
                intra = a_dst != 0 && ((b_src1 == a_dst && !fk) || b_src2 == a_dst);
                bblk = (busy(b_src1) && !fk) || busy(b_src2);
                tbl = (a_grp != b_grp) || (a_grp == 2 && !fpq_full) || fk;
                lone = 1;
                if (a_sreg || b_sreg || m_cnt > 0) reason = "R9";
                else if (a_single || b_single) reason = "R3";
                else if (!tbl) reason = (a_grp == 1) ? "R5" : "R4";
                else if (intra) reason = "R6";
                else if (bblk) reason = "R7";
                else begin
                    lone = 0;
                    reason = fk ? "R5" : "R4";
                end
                if (lone) e_sp = 1; else e_lb = 1;
            end
        end
    endtask

    task automatic update_model();
        if (m_solo) begin
            if (e_la) begin
                m_solo = 0;
                if (m_p_sreg) m_cnt = 3; else if (m_cnt > 0) m_cnt--;
            end
        end else if (e_la) begin
            if (a_sreg) m_cnt = 3; else if (m_cnt > 0) m_cnt--;
            if (e_sp) begin
                m_solo = 1; m_p_sreg = b_sreg; m_p_src1 = b_src1; m_p_src2 = b_src2;
            end
        end
    endtask

    // Called just after a falling edge with the packet already driven.
    task automatic step();
        int unsigned r;
        if (holds >= 2) sb_busy = '0;
        else if (rnd_sb) begin
            r = lcg();
            sb_busy = '0;
            sb_busy[3:1] = r[2:0] & r[5:3];
        end
        #1;
        compute_expected();
        checks++;
        if ({launch_a, launch_b, split, hold, pkt_taken} !== {e_la, e_lb, e_sp, e_hd, e_tk}) begin
            errors++;
            $display("FAIL %s: la,lb,split,hold,taken got %b%b%b%b%b expected %b%b%b%b%b",
                     reason, launch_a, launch_b, split, hold, pkt_taken,
                     e_la, e_lb, e_sp, e_hd, e_tk);
        end
        holds = e_hd ? holds + 1 : 0;
        update_model();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic offer();
        pkt_valid = 1;
        do step(); while (!e_tk);
    endtask

    task automatic set_pkt(logic [1:0] ga, logic [1:0] gb, bit bv,
                           logic [REG_W-1:0] as1, logic [REG_W-1:0] as2, logic [REG_W-1:0] ad,
                           logic [REG_W-1:0] bs1, logic [REG_W-1:0] bs2);
        a_grp = ga; b_grp = gb; b_valid = bv;
        a_src1 = as1; a_src2 = as2; a_dst = ad; b_src1 = bs1; b_src2 = bs2;
        a_single = 0; b_single = 0; a_sreg = 0; b_sreg = 0;
        a_konst_hi = 0; b_konst_lo = 0; fpq_full = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs after reset.
        pkt_valid = 0;
        step();

        // R10: zero register with every scoreboard bit set.
        set_pkt(2'd0, 2'd1, 1, 0, 0, 5, 0, 0);
        sb_busy = '1;
        pkt_valid = 1;
        step();
        sb_busy = '0;

        // R2 then release; R7 slot-b blocked.
        set_pkt(2'd1, 2'd0, 1, 2, 0, 4, 3, 0);
        sb_busy = '0; sb_busy[2] = 1;
        offer();
        set_pkt(2'd1, 2'd0, 1, 1, 0, 4, 3, 0);
        sb_busy = '0; sb_busy[3] = 1;
        step(); sb_busy = '0; offer();

        // R9: special write followed by a run of pairable packets.
        set_pkt(2'd1, 2'd0, 1, 0, 0, 0, 0, 0);
        a_sreg = 1;
        offer();
        for (int k = 0; k < 4; k++) begin
            set_pkt(2'd0, 2'd2, 1, 0, 0, 0, 0, 0);
            offer();
        end

        // R11 lone, R5 fast constant, R6 intra dependency, R4 FP pair with full queue.
        set_pkt(2'd3, 2'd3, 0, 1, 0, 0, 0, 0); offer();
        set_pkt(2'd1, 2'd1, 1, 0, 0, 6, 6, 0);
        a_konst_hi = 1; b_konst_lo = 1; sb_busy = '0; sb_busy[6] = 1;
        offer(); sb_busy = '0;
        set_pkt(2'd1, 2'd2, 1, 0, 0, 7, 0, 7); offer();
        set_pkt(2'd2, 2'd2, 1, 0, 0, 0, 0, 0); fpq_full = 1; offer();
        step();

        // Near-exhaustive sweep: every group pair against every flag variant.
        rnd_sb = 1;
        for (int ga = 0; ga < 4; ga++) begin
            for (int gb = 0; gb < 4; gb++) begin
                for (int v = 0; v < 32; v++) begin
                    int unsigned r;
                    r = lcg();
                    set_pkt(ga[1:0], gb[1:0], v != 31,
                            REG_W'(r[1:0]), REG_W'(r[3:2]), REG_W'(r[5:4]),
                            REG_W'(r[7:6]), REG_W'(r[9:8]));
                    a_single = (v == 1); b_single = (v == 2);
                    a_sreg = (v == 3); b_sreg = (v == 4);
                    fpq_full = v[0];
                    if (v == 10 || v == 11 || v == 26 || v == 27) begin
                        a_konst_hi = 1; b_konst_lo = 1;
                        if (a_dst != 0) b_src1 = a_dst;
                    end
                    offer();
                end
            end
        end
        rnd_sb = 0;
        pkt_valid = 0;
        step(); step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule